// File: doc/BRIEF.md
# Port Pin Interrupt Detector

This block watches eight general-purpose input pins and raises one interrupt request line toward the CPU when a selected pin shows a chosen transition or, in the combined mode, holds a chosen level. Each pin can be switched in or out of detection on its own. Each pin also has a polarity bit: 0 selects falling or low, and 1 selects rising or high. One shared mode bit decides whether enabled pins react to edges only or to both edges and held levels. Pin inputs are asynchronous. Each one passes through a two-flop synchroniser before any detection logic sees it.

Software reaches the block through three byte-wide registers on a simple peripheral bus. Writes take one cycle and reads return the value in the same cycle. A status-and-control register holds a sticky detection flag, a write-only acknowledge bit, the request enable and the mode bit. The flag records that a detection happened. Software clears it by writing 1 to the acknowledge bit. The request line is active only while the flag is set and the enable is on.

Top module: `pin_irq_detector`

## Requirements
- R1: After a synchronous active-low reset, the status, pin-enable and polarity registers all read 0x00 and `irq_o` is 0.
- R2: The status register is at address 0. Bit 3 is the flag, bit 2 is acknowledge, bit 1 is the request enable and bit 0 is the mode. Bits 7..4 and bit 2 always read as 0. Bits 1 and 0 read back the last value written.
- R3: The flag is read-only. Writing 1 to bit 3 of the status register does not set it.
- R4: A status write with bit 2 set clears the flag when no detection is active in that cycle. A status write with bit 2 clear leaves the flag unchanged.
- R5: `irq_o` is 1 exactly when the flag is 1 and the request enable is 1. The flag still sets while the enable is 0.
- R6: With mode 0, an enabled pin whose polarity bit is 1 sets the flag on a rising edge only. An enabled pin whose polarity bit is 0 sets the flag on a falling edge only.
- R7: With mode 1, an enabled pin held at its active level keeps the flag set, so an acknowledge does not clear it. Once the pin leaves that level, an acknowledge clears the flag.
- R8: With mode 0, a pin that stays at its active level after an acknowledge does not set the flag again.
- R9: A pin whose enable bit is 0 never sets the flag, in either mode and for either polarity.
- R10: When a detection and an acknowledge write occur in the same clock cycle, the flag stays set.
- R11: A pin change made between clock edges shows in the flag after the third rising edge and not after the second.
- R12: The pin-enable register (address 1) and the polarity register (address 2) are 8 bits wide and read back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pins_i | input | 8 | Asynchronous pin levels |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 status, 1 pin enable, 2 polarity |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the address |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
A detection event and a software acknowledge can both target the flag in the same clock cycle. The bench provokes this in edge mode. It first sets the flag, then arms a second rising edge and places the acknowledge write so that it is captured on the same clock edge where the synchronised edge is seen. It judges the result by reading the flag back as still set, then checks that a later plain acknowledge clears it. In level mode, the same collision happens whenever software acknowledges while a pin is still held active, and the bench checks that case as well.

// File: rtl/pinirq_pkg.sv
// Package: shared constants for the port pin interrupt detector.
// Assumes: bus data is one byte and the register file has at most four addresses.
package pinirq_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADR_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_ENA  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_POL  = 2'd2;

    // Status register bit positions (software decodes these)
    localparam int ST_FLAG = 3;
    localparam int ST_ACK  = 2;
    localparam int ST_IE   = 1;
    localparam int ST_MODE = 0;
endpackage

// File: rtl/pinirq_sync.sv
// Module: pinirq_sync
// Brings each asynchronous pin into the clock domain with two flops.
// Assumes: pins are quasi-static compared with the clock; reset is synchronous, active low.
module pinirq_sync #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pins_async,
    output logic [PINS-1:0] pins_sync
);
    logic [PINS-1:0] meta_q;
    logic [PINS-1:0] sync_q;

    // Two-stage capture of the raw pin levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pins_async;
            sync_q <= meta_q;
        end
    end

    assign pins_sync = sync_q;

    // R11: the second stage follows the first one cycle later
    a_r11_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sync_q == $past(meta_q)));
endmodule

// File: rtl/pinirq_detect.sv
// Module: pinirq_detect
// Turns synchronised pin levels into per-pin detection events.
// Edge events compare the current and previous synchronised sample.
// Level events are added when the mode input is 1.
// Assumes: inputs are already synchronous to clk.
module pinirq_detect #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] lvl,
    input  logic [PINS-1:0] pin_en,
    input  logic [PINS-1:0] pin_pol,
    input  logic            level_mode,
    output logic [PINS-1:0] events,
    output logic            any_event
);
    logic [PINS-1:0] prev_q;

    // Keep last cycle's synchronised sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // Per-pin event logic, one slice per pin
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic rise, fall, at_level;
        always_comb begin
            rise     = lvl[i] & ~prev_q[i];
            fall     = ~lvl[i] & prev_q[i];
            at_level = pin_pol[i] ? lvl[i] : ~lvl[i];
            events[i] = pin_en[i] &
                        ((pin_pol[i] ? rise : fall) | (level_mode & at_level));
        end
    end

    assign any_event = |events;

    // R9: a disabled pin never produces an event
    a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (events & ~pin_en) == '0);

    // R8: in edge mode an event needs a change of the sampled level
    a_r8_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && any_event) |-> (lvl != prev_q));
endmodule

// File: rtl/pinirq_regs.sv
// Module: pinirq_regs
// Register file and sticky flag: status/control, pin enable and polarity.
// Detection takes priority over acknowledge when both fall in one cycle.
// Assumes: PINS <= DATA_W; single-cycle writes; reads are combinational.
module pinirq_regs
    import pinirq_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              any_event,
    output logic [PINS-1:0]   pin_en,
    output logic [PINS-1:0]   pin_pol,
    output logic              level_mode,
    output logic              flag,
    output logic              irq_en
);
    logic [PINS-1:0] en_q, pol_q;
    logic            mode_q, ie_q, flag_q;
    logic            wr_stat, wr_ena, wr_pol, ack_wr;

    // Write strobes for each register
    always_comb begin
        wr_stat = bus_sel && bus_wr && (bus_addr == ADR_STAT);
        wr_ena  = bus_sel && bus_wr && (bus_addr == ADR_ENA);
        wr_pol  = bus_sel && bus_wr && (bus_addr == ADR_POL);
        ack_wr  = wr_stat && bus_wdata[ST_ACK];
    end

    // Control fields written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            mode_q <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (wr_ena)  en_q  <= bus_wdata[PINS-1:0];
            if (wr_pol)  pol_q <= bus_wdata[PINS-1:0];
            if (wr_stat) begin
                mode_q <= bus_wdata[ST_MODE];
                ie_q   <= bus_wdata[ST_IE];
            end
        end
    end

    // Sticky flag: set by detection, cleared by acknowledge, detection wins
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (any_event) flag_q <= 1'b1;
        else if (ack_wr)    flag_q <= 1'b0;
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_STAT: begin
                bus_rdata[ST_FLAG] = flag_q;
                bus_rdata[ST_IE]   = ie_q;
                bus_rdata[ST_MODE] = mode_q;
            end
            ADR_ENA: bus_rdata = DATA_W'(en_q);
            ADR_POL: bus_rdata = DATA_W'(pol_q);
            default: bus_rdata = '0;
        endcase
    end

    assign pin_en     = en_q;
    assign pin_pol    = pol_q;
    assign level_mode = mode_q;
    assign flag       = flag_q;
    assign irq_en     = ie_q;

    // R10: an event always leaves the flag set on the next cycle
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any_event |=> flag_q);

    // R4: an acknowledge without a competing event clears the flag
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !any_event) |=> !flag_q);

    // R3: the flag only rises after a detection event
    a_r3_flag_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(any_event));

    // R2: unimplemented bits and the acknowledge bit read as zero
    a_r2_stat_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_STAT) |-> (bus_rdata[7:4] == 4'b0 && !bus_rdata[ST_ACK]));
endmodule

// File: rtl/pin_irq_detector.sv
// Module: pin_irq_detector (top)
// Eight-pin interrupt detector: synchroniser, event detector, register file
// and request output. irq_o is active while the flag and request enable are both set.
// Assumes: synchronous active-low reset; pins are asynchronous to clk.
module pin_irq_detector
    import pinirq_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pins_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [PINS-1:0] lvl, pin_en, pin_pol, events;
    logic            level_mode, any_event, flag, irq_en;

    pinirq_sync #(.PINS(PINS)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_async (pins_i),
        .pins_sync  (lvl)
    );

    pinirq_detect #(.PINS(PINS)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl),
        .pin_en     (pin_en),
        .pin_pol    (pin_pol),
        .level_mode (level_mode),
        .events     (events),
        .any_event  (any_event)
    );

    pinirq_regs #(.PINS(PINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .any_event  (any_event),
        .pin_en     (pin_en),
        .pin_pol    (pin_pol),
        .level_mode (level_mode),
        .flag       (flag),
        .irq_en     (irq_en)
    );

    // Request output: gated flag
    assign irq_o = flag & irq_en;

    // R5: no request while the enable is off
    a_r5_gated_request: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o);
endmodule

// File: tb/test_pin_irq_detector.sv
// Directed bench for pin_irq_detector: one task per scenario.
module test_pin_irq_detector;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins_i = '0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_detector i_pin_irq_detector (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_i    (pins_i),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pins_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd0, 8'h03);
        do_reset();
        rd(2'd0, v); chk("R1 status", v, 8'h00);
        rd(2'd1, v); chk("R1 enable", v, 8'h00);
        rd(2'd2, v); chk("R1 polarity", v, 8'h00);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        do_reset();
        wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
        rd(2'd1, v); chk("R12 enable", v, 8'hA5);
        rd(2'd2, v); chk("R12 polarity", v, 8'h3C);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hF7);
        rd(2'd0, v); chk("R2 status read", v, 8'h03);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R2 status cleared", v, 8'h00);
    endtask

    task automatic t_flag_ro();
        logic [7:0] v;
        do_reset();
        wr(2'd0, 8'h08);
        step(2);
        rd(2'd0, v); chk("R3 flag not writable", v, 8'h00);
    endtask

    task automatic t_edge();
        logic [7:0] v;
        do_reset();
        wr(2'd1, 8'h21); wr(2'd2, 8'h01);
        @(negedge clk); pins_i[0] = 1'b1;
        step(2); rd(2'd0, v); chk("R11 not after two edges", v, 8'h00);
        step(1); rd(2'd0, v); chk("R11 set after three edges", v, 8'h08);
        wr(2'd0, 8'h04);
        @(negedge clk); pins_i[0] = 1'b0;
        step(4); rd(2'd0, v); chk("R6 falling ignored with polarity 1", v, 8'h00);
        @(negedge clk); pins_i[5] = 1'b1;
        step(4); rd(2'd0, v); chk("R6 rising ignored with polarity 0", v, 8'h00);
        @(negedge clk); pins_i[5] = 1'b0;
        step(4); rd(2'd0, v); chk("R6 falling seen with polarity 0", v, 8'h08);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        do_reset();
        wr(2'd1, 8'h01); wr(2'd2, 8'h01);
        @(negedge clk); pins_i[0] = 1'b1;
        step(4);
        rd(2'd0, v); chk("R5 flag sets with enable off", v, 8'h08);
        chk("R5 no request with enable off", {7'b0, irq_o}, 8'h00);
        wr(2'd0, 8'h02);
        rd(2'd0, v); chk("R4 write without ack keeps flag", v, 8'h0A);
        chk("R5 request with flag and enable", {7'b0, irq_o}, 8'h01);
        wr(2'd0, 8'h06);
        rd(2'd0, v); chk("R4 ack clears flag", v, 8'h02);
        chk("R5 request drops", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_hold_edge();
        logic [7:0] v;
        do_reset();
        wr(2'd1, 8'h01); wr(2'd2, 8'h01);
        @(negedge clk); pins_i[0] = 1'b1;
        step(4);
        wr(2'd0, 8'h04);
        step(4);
        rd(2'd0, v); chk("R8 held level no re-trigger in edge mode", v, 8'h00);
    endtask

    task automatic t_level();
        logic [7:0] v;
        do_reset();
        wr(2'd1, 8'h01); wr(2'd2, 8'h01); wr(2'd0, 8'h01);
        @(negedge clk); pins_i[0] = 1'b1;
        step(5);
        wr(2'd0, 8'h05);
        rd(2'd0, v); chk("R7 ack while level held keeps flag", v, 8'h09);
        @(negedge clk); pins_i[0] = 1'b0;
        step(3);
        wr(2'd0, 8'h05);
        rd(2'd0, v); chk("R7 ack after level leaves", v, 8'h01);
        wr(2'd2, 8'h00);
        step(1);
        rd(2'd0, v); chk("R7 low level with polarity 0", v, 8'h09);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        do_reset();
        wr(2'd1, 8'hF7); wr(2'd2, 8'h08);
        @(negedge clk); pins_i[3] = 1'b1;
        step(4);
        @(negedge clk); pins_i[3] = 1'b0;
        step(4);
        rd(2'd0, v); chk("R9 disabled pin edges", v, 8'h00);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h01);
        step(3);
        rd(2'd0, v); chk("R9 disabled pins in level mode", v, 8'h01);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        do_reset();
        wr(2'd1, 8'h01); wr(2'd2, 8'h01);
        @(negedge clk); pins_i[0] = 1'b1;
        step(4);
        @(negedge clk); pins_i[0] = 1'b0;
        step(4);
        rd(2'd0, v); chk("R10 flag set before collision", v, 8'h08);
        @(negedge clk); pins_i[0] = 1'b1;
        step(1);
        wr(2'd0, 8'h04);
        rd(2'd0, v); chk("R10 event beats ack", v, 8'h08);
        wr(2'd0, 8'h04);
        rd(2'd0, v); chk("R10 later ack clears", v, 8'h00);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_regs();
        t_flag_ro();
        t_edge();
        t_irq();
        t_hold_edge();
        t_level();
        t_disabled();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule